// File: doc/BRIEF.md
# Multiplier-Free Linear-Phase DC Blocker with Leading Integrator

This block takes a stream of signed samples, optionally runs them through a one-pole integrator, and strips the slowly varying offset from the result. A typical use is turning a square wave into a triangle wave. The integrator builds the triangle, and any asymmetry in the square wave makes its baseline wander. The blocker estimates that baseline and removes it. The baseline estimate comes from a cascade of four moving-average sections. Each section has length D = 2^LEN_LOG2, so every divide is an arithmetic right shift, and the datapath contains no multiplier.

The estimate is subtracted from a copy of the integrator output delayed by 2D-2 samples. That delay matches the group delay of the cascade, so the overall response has linear phase. With the default D = 64, the delay is 126 samples. One sample is accepted on each cycle where `in_valid` is high. The matching result appears one cycle later, flagged by `out_valid`. Nothing moves on cycles where `in_valid` is low.

Top module: `ma_dc_blocker`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_data` is 0. Every history, running sum and the integrator are cleared, so samples after reset behave as if preceded by zeros.
- R2: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high, including the first 4D samples of settling, and low otherwise.
- R3: With `integ_on` = 1, the stage value is y[n] = y[n-1] + x[n], where x is `in_data` sign-extended to SIG_W bits, wrapping modulo 2^SIG_W in two's complement. With `integ_on` = 0, y[n] = x[n] and the integrator state is cleared to 0.
- R4: Each of the four cascaded sections outputs floor(sum of its last D inputs / D), computed as an arithmetic right shift by LEN_LOG2. The first section's input is y, and each later section takes the previous section's output.
- R5: For accepted sample n, the next cycle's `out_data` equals y[n-(2D-2)] minus the fourth section's output, as a signed SIG_W+1 bit value.
- R6: A cycle with `in_valid` low changes neither the output nor any stored state.
- R7: After a linear ramp has been present for 4D samples, `out_data` stays within ±4. The ramp can come from a constant input with the integrator on, or from an offset plus a unit slope with it off.
- R8: A constant input with the integrator off gives `out_data` exactly 0 once 4D samples of it have been accepted.
- R9: A sinusoid whose period divides D, with the integrator off, leaves the block unchanged after 4D samples except for a delay of exactly 2D-2 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | IN_W | Signed input sample |
| integ_on | input | 1 | 1 enables the leading integrator, 0 bypasses and clears it |
| out_valid | output | 1 | Output strobe, one cycle after `in_valid` |
| out_data | output | SIG_W+1 | Signed offset-free sample |

## Verification
The assertions check every cycle that the output strobe follows the input strobe with one cycle of delay. They also check that idle cycles freeze the output, the integrator and the history pointer, that the pointer advances once per sample, and that bypassing clears the integrator. The numeric behaviour is shown only by the bench, which compares every output against a queue-based model. That covers the floor-averaged cascade, the exact 2D-2 alignment, integrator wrap, offset and ramp removal, and the undisturbed passage of a sinusoid.

// File: rtl/ma_dc_blocker.sv
module ma_dc_blocker #(
  parameter int IN_W     = 16,
  parameter int SIG_W    = 24,
  parameter int LEN_LOG2 = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [IN_W-1:0]    in_data,
  input  logic               integ_on,
  output logic               out_valid,
  output logic [SIG_W:0]     out_data
);
  localparam int D     = 1 << LEN_LOG2;
  localparam int NSEC  = 4;
  localparam int SUM_W = SIG_W + LEN_LOG2;
  localparam int OUT_W = SIG_W + 1;
  localparam int PW    = LEN_LOG2 + 1;

  logic signed [SIG_W-1:0] x_ext, y, integ_q;
  logic [PW-1:0] wp, comp_rd;
  logic [LEN_LOG2-1:0] sec_rd;
  logic [NSEC:0][SIG_W-1:0] u;

  assign x_ext = {{(SIG_W-IN_W){in_data[IN_W-1]}}, in_data};
  assign y     = integ_on ? integ_q + x_ext : x_ext;
  assign u[0]  = y;
  assign sec_rd  = wp[LEN_LOG2-1:0];
  assign comp_rd = wp + PW'(2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      integ_q <= '0;
      wp      <= '0;
    end else if (in_valid) begin
      integ_q <= integ_on ? y : '0;
      wp      <= wp + PW'(1);
    end
  end

  for (genvar k = 0; k < NSEC; k++) begin : g_sec
    logic signed [SIG_W-1:0] hist [0:D-1];
    logic signed [SIG_W-1:0] cur, old;
    logic signed [SUM_W-1:0] acc_q, acc_nx;

    assign cur      = u[k];
    assign old      = hist[sec_rd];
    assign acc_nx   = acc_q + SUM_W'(cur) - SUM_W'(old);
    assign u[k+1]   = acc_nx[SUM_W-1:LEN_LOG2];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc_q <= '0;
        for (int i = 0; i < D; i++) hist[i] <= '0;
      end else if (in_valid) begin
        acc_q        <= acc_nx;
        hist[sec_rd] <= cur;
      end
    end
  end

  logic signed [SIG_W-1:0] comp [0:2*D-1];
  logic signed [SIG_W-1:0] aligned, base;

  assign aligned = comp[comp_rd];
  assign base    = u[NSEC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2*D; i++) comp[i] <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        comp[wp] <= y;
        out_data <= OUT_W'(aligned) - OUT_W'(base);
      end
    end
  end
endmodule

// File: rtl/ma_dc_blocker_chk.sv
module ma_dc_blocker_chk #(
  parameter int SIG_W    = 24,
  parameter int LEN_LOG2 = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                integ_on,
  input logic                out_valid,
  input logic [SIG_W:0]      out_data,
  input logic [SIG_W-1:0]    integ_q,
  input logic [LEN_LOG2:0]   wp
);
  assert_strobe_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_strobe_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(integ_q) && $stable(wp)));
  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (wp == $past(wp) + 1'b1));
  assert_bypass_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !integ_on) |=> (integ_q == '0));
endmodule

bind ma_dc_blocker ma_dc_blocker_chk #(.SIG_W(SIG_W), .LEN_LOG2(LEN_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .integ_on(integ_on),
  .out_valid(out_valid), .out_data(out_data), .integ_q(integ_q), .wp(wp)
);

// File: tb/tb_ma_dc_blocker.sv
`timescale 1ns/1ps
module tb_ma_dc_blocker;
  localparam int IN_W = 16, SIG_W = 24, LEN_LOG2 = 6;
  localparam int D = 1 << LEN_LOG2;

  logic clk = 0, rst_n = 0, in_valid = 0, integ_on = 0;
  logic [IN_W-1:0] in_data = '0;
  logic out_valid;
  logic [SIG_W:0] out_data;

  ma_dc_blocker #(.IN_W(IN_W), .SIG_W(SIG_W), .LEN_LOG2(LEN_LOG2)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .integ_on(integ_on), .out_valid(out_valid), .out_data(out_data));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  longint sq0[$], sq1[$], sq2[$], sq3[$], dq[$], xh[$];
  longint integ_m, last_out;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint wrapv(input longint v);
    longint m = v & ((longint'(1) << SIG_W) - 1);
    if (m >= (longint'(1) << (SIG_W-1))) m -= (longint'(1) << SIG_W);
    return m;
  endfunction

  task automatic model_reset();
    sq0 = {}; sq1 = {}; sq2 = {}; sq3 = {}; dq = {}; xh = {};
    for (int i = 0; i < D; i++) begin
      sq0.push_back(0); sq1.push_back(0); sq2.push_back(0); sq3.push_back(0);
    end
    for (int i = 0; i < 2*D-2; i++) dq.push_back(0);
    integ_m = 0; last_out = 0;
  endtask

  function automatic longint qsum(ref longint q[$]);
    longint s = 0;
    foreach (q[i]) s += q[i];
    return s;
  endfunction

  // R4: four floor averages over D samples; R5: delayed value minus the last average
  task automatic model_step(input longint x, input bit on, output longint res);
    longint yv, del, m;
    yv = on ? wrapv(integ_m + x) : x;
    integ_m = on ? yv : 0;
    dq.push_back(yv); del = dq.pop_front();
    sq0.push_back(yv); void'(sq0.pop_front()); m = qsum(sq0) >>> LEN_LOG2;
    sq1.push_back(m);  void'(sq1.pop_front()); m = qsum(sq1) >>> LEN_LOG2;
    sq2.push_back(m);  void'(sq2.pop_front()); m = qsum(sq2) >>> LEN_LOG2;
    sq3.push_back(m);  void'(sq3.pop_front()); m = qsum(sq3) >>> LEN_LOG2;
    res = del - m;
  endtask

  task automatic sample(input bit v, input longint x, input bit on, input string req,
                        output longint got);
    longint exp;
    in_valid = v; in_data = x[IN_W-1:0]; integ_on = on;
    @(negedge clk);
    got = longint'($signed(out_data));
    if (v) begin
      xh.push_back(x);
      model_step(x, on, exp);
      chk(out_valid === 1'b1, "R2", longint'(out_valid), 1);
      chk(got == exp, req, got, exp);
      last_out = exp;
    end else begin
      chk(out_valid === 1'b0, "R2", longint'(out_valid), 0);
      chk(got == last_out, "R6", got, last_out);
    end
  endtask

  task automatic do_reset();
    in_valid = 0; rst_n = 0;
    repeat (2) @(negedge clk);
    chk(out_valid === 1'b0, "R1", longint'(out_valid), 0);
    chk(out_data == '0, "R1", longint'($signed(out_data)), 0);
    model_reset();
    rst_n = 1;
  endtask

  function automatic longint sine16(input int n);
    real r = 3000.0 * $sin(2.0 * 3.14159265358979 * real'(n % 16) / 16.0);
    longint a = longint'($rtoi((r < 0.0 ? -r : r) + 0.5));
    return (r < 0.0) ? -a : a;
  endfunction

  initial begin
    longint got;
    longint worst;
    model_reset();
    repeat (3) @(negedge clk);
    do_reset();

    // R8: constant with integrator off, exact zero after settling
    for (int n = 0; n < 4*D + 10; n++) begin
      sample(1, 1000, 0, "R5", got);
      if (n >= 4*D) chk(got == 0, "R8", got, 0);
    end

    // R6: idle gaps interleaved with samples
    for (int n = 0; n < 40; n++) begin
      sample(1, -700 + 13*n, 0, "R5", got);
      sample(0, 12345, 1, "R6", got);
      sample(0, -1, 0, "R6", got);
    end

    // R7: integrated constant gives a ramp that is removed
    do_reset();
    worst = 0;
    for (int n = 0; n < 4*D + 60; n++) begin
      sample(1, 3, 1, "R3", got);
      if (n >= 4*D && (got > 4 || got < -4)) worst = got;
    end
    chk(worst == 0, "R7", worst, 0);

    // R7: offset step plus slow ramp, integrator off
    worst = 0;
    for (int n = 0; n < 4*D + 60; n++) begin
      sample(1, -4000 + n, 0, "R5", got);
      if (n >= 4*D && (got > 4 || got < -4)) worst = got;
    end
    chk(worst == 0, "R7", worst, 0);

    // R9: period-16 sinusoid passes, delayed by 2D-2
    do_reset();
    for (int n = 0; n < 4*D + 40; n++) begin
      sample(1, sine16(n), 0, "R5", got);
      if (n >= 4*D) chk(got == xh[n-(2*D-2)], "R9", got, xh[n-(2*D-2)]);
    end

    // R3: integrator wraps modulo 2^SIG_W, then toggles on and off
    do_reset();
    for (int n = 0; n < 700; n++) sample(1, 30000, 1, "R3", got);
    for (int n = 0; n < 200; n++) sample(1, -20000 + 50*n, n[3], "R3", got);

    // R1: reset in mid-stream clears all history
    for (int n = 0; n < 30; n++) sample(1, -25000, 1, "R5", got);
    do_reset();
    sample(1, 1000, 0, "R1", got);
    chk(got == 0, "R1", got, 0);
    for (int n = 0; n < 20; n++) sample(1, 500 - n, 0, "R5", got);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule